// File: doc/BRIEF.md
# Two-Bank Rectangle Fill Engine

This block paints a solid rectangle of 16-bit pixels into a 1024x512 frame buffer. The frame buffer is split across two 16-bit memory banks. Bank 0 holds the even-numbered pixels of each row and bank 1 holds the odd-numbered ones. Each bank has its own address bus, so the two halves of a pixel pair can be written at different addresses in the same cycle. A command carries a start corner, a size, a colour and a compatibility bit. It is handed over with a valid/ready handshake. The engine then writes one pixel pair per cycle, left to right across a row and then row by row, and reports completion with a one-cycle pulse.

The horizontal start is snapped down to a 16-pixel boundary and the width is padded up to a whole number of 16-pixel groups. When the compatibility bit is set, the engine reproduces an old two-bank rounding defect. If the low four bits of the start column are all ones, bank 0 computes its start as the next boundary up, while bank 1 keeps the boundary below. The even and odd pixels therefore land in two horizontally offset stripes. Memory arbitration, refresh and display scan-out belong to other blocks.

Top module: `rect_fill_2bank`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `busy`, `done`, `b0_we` and `b1_we` are 0.
- R2: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both 1. From the next cycle until the engine returns to idle, `busy` is 1 and `cmd_ready` is 0.
- R3: With `cmd_quirk` = 0, the fill starts at column `x` rounded down to a multiple of 16, for both banks alike. For example, every x in 00h..0Fh starts at 0, and every x in 10h..1Fh starts at 10h.
- R4: The width is rounded up to a multiple of 16 pixels, giving `ceil(w/16)*8` pairs per row. Pairs are written one per cycle with no gaps, in row-major order, starting the cycle after acceptance.
- R5: For a pair that covers lane column `lx`, the bank address is `row*512 + lx/2`. Bank 0 carries even pixel columns and bank 1 carries odd ones.
- R6: With `cmd_quirk` = 1 and `x[3:0]` = 1111b, bank 0 starts at x rounded up to the next multiple of 16, while bank 1 starts at x rounded down. For example, x=0Fh with w=20h makes bank 0 cover columns 10h..2Fh and bank 1 cover 00h..1Fh.
- R7: With `cmd_quirk` = 1 and `x[3:0]` not all ones, the addresses match the `cmd_quirk` = 0 case.
- R8: Columns wrap modulo 1024 and rows wrap modulo 512, including the bank 0 round-up in quirk mode.
- R9: Both banks receive the command colour, and their write enables are asserted together.
- R10: `done` is high for exactly one cycle, the cycle after the last write. `busy` is still 1 during that cycle, and the following cycle is idle with `cmd_ready` = 1.
- R11: A command with width 0 or height 0 performs no write and pulses `done` in the cycle after acceptance.
- R12: `cmd_valid` and the command fields are ignored while busy. The running fill continues unchanged, and no extra writes follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_x | input | 10 | Start column |
| cmd_y | input | 9 | Start row |
| cmd_w | input | 11 | Width in pixels |
| cmd_h | input | 10 | Height in rows |
| cmd_colour | input | 16 | Fill colour |
| cmd_quirk | input | 1 | 1 = reproduce the two-bank rounding defect |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| b0_we | output | 1 | Bank 0 (even pixels) write enable |
| b0_addr | output | 18 | Bank 0 word address |
| b0_data | output | 16 | Bank 0 write data |
| b1_we | output | 1 | Bank 1 (odd pixels) write enable |
| b1_addr | output | 18 | Bank 1 word address |
| b1_data | output | 16 | Bank 1 write data |

## Verification
Starts at x=0 and x=0Fh with the compatibility bit clear show that both lanes are snapped down together. The same x=0Fh and x=1Fh starts with the bit set must split the lanes by exactly eight words, while x=17h with the bit set must not split them. Widths of 1 and 11h exercise the padding to 16-pixel groups. A start near the right and bottom edges exercises wrapping of columns, rows and the quirk round-up. Zero-sized commands, and a second command presented mid-fill, show that only an accepted command can cause writes.

// File: rtl/rfill_pkg.sv
package rfill_pkg;

    localparam int XW    = 10;          // column bits (1024 pixels)
    localparam int YW    = 9;           // row bits (512 rows)
    localparam int PW    = 16;          // pixel bits
    localparam int ALG   = 4;           // log2 of horizontal alignment
    localparam int WW    = XW + 1;      // width field bits
    localparam int HW    = YW + 1;      // height field bits
    localparam int CW    = XW + 1;      // pair counter bits
    localparam int PXW   = XW - 1;      // pair column bits per bank
    localparam int AW    = YW + PXW;    // bank address bits
    localparam int GW    = XW - ALG;    // alignment group index bits
    localparam int LANES = 2;

    typedef struct packed {
        logic [XW-1:0] x;
        logic [YW-1:0] y;
        logic [WW-1:0] w;
        logic [HW-1:0] h;
        logic [PW-1:0] colour;
        logic          quirk;
    } fill_cmd_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FILL   = 2'd1,
        ST_FINISH = 2'd2
    } fill_state_t;

    // Pairs per row: width padded up to whole groups, two pixels per pair.
    function automatic logic [CW-1:0] row_pairs(input logic [WW-1:0] w);
        logic [WW:0] groups;
        logic [WW:0] pairs;
        groups = ({1'b0, w} + (WW+1)'((1 << ALG) - 1)) >> ALG;
        pairs  = groups << (ALG - 1);
        return pairs[CW-1:0];
    endfunction

    // Starting pair column for one bank lane.
    function automatic logic [PXW-1:0] lane_base(input logic [XW-1:0] x,
                                                 input logic quirk,
                                                 input int lane);
        logic [GW-1:0] grp;
        grp = x[XW-1:ALG];
        if (quirk && (lane == 0) && (&x[ALG-1:0]))
            grp = grp + GW'(1);
        return {grp, {(ALG-1){1'b0}}};
    endfunction

endpackage

// File: rtl/rfill_seq.sv
module rfill_seq
    import rfill_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  fill_cmd_t       in_cmd,
    output logic            in_ready,
    output logic            busy,
    output logic            done,
    output logic            wr_act,
    output fill_cmd_t       cmd_q,
    output logic [YW-1:0]   cur_row,
    output logic [CW-1:0]   pair_idx
);

    fill_state_t   state;
    logic [HW-1:0] row_cnt;
    logic [CW-1:0] pairs_tot;
    logic          last_pair;
    logic          last_row;

    assign last_pair = (pair_idx == pairs_tot - CW'(1));
    assign last_row  = (row_cnt == cmd_q.h - HW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cmd_q     <= '0;
            row_cnt   <= '0;
            pair_idx  <= '0;
            pairs_tot <= '0;
            cur_row   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (in_valid) begin
                        cmd_q     <= in_cmd;
                        pairs_tot <= row_pairs(in_cmd.w);
                        pair_idx  <= '0;
                        row_cnt   <= '0;
                        cur_row   <= in_cmd.y;
                        if (in_cmd.w == '0 || in_cmd.h == '0)
                            state <= ST_FINISH;
                        else
                            state <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (last_pair) begin
                        pair_idx <= '0;
                        cur_row  <= cur_row + YW'(1);
                        row_cnt  <= row_cnt + HW'(1);
                        if (last_row)
                            state <= ST_FINISH;
                    end else begin
                        pair_idx <= pair_idx + CW'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign in_ready = (state == ST_IDLE);
    assign busy     = (state != ST_IDLE);
    assign done     = (state == ST_FINISH);
    assign wr_act   = (state == ST_FILL);

    a_r2_accept_busy: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> busy);

    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r10_done_after_fill: assert property (@(posedge clk) disable iff (rst)
        $fell(wr_act) |-> done);

    a_r12_cmd_held: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cmd_q));

endmodule

// File: rtl/rfill_lane_addr.sv
module rfill_lane_addr
    import rfill_pkg::*;
#(
    parameter int LANE = 0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            active,
    input  logic [XW-1:0]   x,
    input  logic            quirk,
    input  logic [YW-1:0]   row,
    input  logic [CW-1:0]   pair_idx,
    output logic [AW-1:0]   addr
);

    logic [PXW-1:0] base;
    logic [PXW-1:0] col;

    assign base = lane_base(x, quirk, LANE);
    assign col  = base + pair_idx[PXW-1:0];
    assign addr = {row, col};

    a_r4_step: assert property (@(posedge clk) disable iff (rst)
        ($past(active) && active && pair_idx != '0)
            |-> (addr[PXW-1:0] == $past(addr[PXW-1:0]) + PXW'(1)));

endmodule

// File: rtl/rect_fill_2bank.sv
module rect_fill_2bank
    import rfill_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_valid,
    output logic            cmd_ready,
    input  logic [XW-1:0]   cmd_x,
    input  logic [YW-1:0]   cmd_y,
    input  logic [WW-1:0]   cmd_w,
    input  logic [HW-1:0]   cmd_h,
    input  logic [PW-1:0]   cmd_colour,
    input  logic            cmd_quirk,
    output logic            busy,
    output logic            done,
    output logic            b0_we,
    output logic [AW-1:0]   b0_addr,
    output logic [PW-1:0]   b0_data,
    output logic            b1_we,
    output logic [AW-1:0]   b1_addr,
    output logic [PW-1:0]   b1_data
);

    fill_cmd_t      in_cmd;
    fill_cmd_t      cmd_q;
    logic           wr_act;
    logic [YW-1:0]  cur_row;
    logic [CW-1:0]  pair_idx;
    logic [AW-1:0]  lane_addr [LANES];

    assign in_cmd = '{x: cmd_x, y: cmd_y, w: cmd_w, h: cmd_h,
                      colour: cmd_colour, quirk: cmd_quirk};

    rfill_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .in_valid (cmd_valid),
        .in_cmd   (in_cmd),
        .in_ready (cmd_ready),
        .busy     (busy),
        .done     (done),
        .wr_act   (wr_act),
        .cmd_q    (cmd_q),
        .cur_row  (cur_row),
        .pair_idx (pair_idx)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        rfill_lane_addr #(.LANE(g)) u_addr (
            .clk      (clk),
            .rst      (rst),
            .active   (wr_act),
            .x        (cmd_q.x),
            .quirk    (cmd_q.quirk),
            .row      (cur_row),
            .pair_idx (pair_idx),
            .addr     (lane_addr[g])
        );
    end

    assign b0_we   = wr_act;
    assign b1_we   = wr_act;
    assign b0_addr = lane_addr[0];
    assign b1_addr = lane_addr[1];
    assign b0_data = cmd_q.colour;
    assign b1_data = cmd_q.colour;

    a_r9_we_busy: assert property (@(posedge clk) disable iff (rst)
        (b0_we || b1_we) |-> busy);

    a_r3_lanes_equal: assert property (@(posedge clk) disable iff (rst)
        (b0_we && !cmd_q.quirk) |-> (b0_addr == b1_addr));

    a_r6_lane_offset: assert property (@(posedge clk) disable iff (rst)
        (b0_we && cmd_q.quirk && (&cmd_q.x[ALG-1:0]))
            |-> (b0_addr[PXW-1:0] == b1_addr[PXW-1:0] + PXW'(1 << (ALG-1))));

endmodule

// File: tb/tb_rect_fill_2bank.sv
module tb_rect_fill_2bank;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic        cmd_ready;
    logic [9:0]  cmd_x;
    logic [8:0]  cmd_y;
    logic [10:0] cmd_w;
    logic [9:0]  cmd_h;
    logic [15:0] cmd_colour;
    logic        cmd_quirk;
    logic        busy, done;
    logic        b0_we, b1_we;
    logic [17:0] b0_addr, b1_addr;
    logic [15:0] b0_data, b1_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    rect_fill_2bank dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_x(cmd_x), .cmd_y(cmd_y), .cmd_w(cmd_w), .cmd_h(cmd_h),
        .cmd_colour(cmd_colour), .cmd_quirk(cmd_quirk),
        .busy(busy), .done(done),
        .b0_we(b0_we), .b0_addr(b0_addr), .b0_data(b0_data),
        .b1_we(b1_we), .b1_addr(b1_addr), .b1_data(b1_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_fill(input string tag, input int x, input int y, input int w,
                            input int h, input int col, input bit q, input bit inject);
        int pairs, total, idx, b0_base, t;
        bit seen_done;
        pairs   = ((w + 15) / 16) * 8;
        total   = (w == 0 || h == 0) ? 0 : pairs * h;
        b0_base = (x >> 4);
        if (q && ((x & 15) == 15)) b0_base = (b0_base + 1) % 64;
        @(negedge clk);
        cmd_x = x[9:0]; cmd_y = y[8:0]; cmd_w = w[10:0]; cmd_h = h[9:0];
        cmd_colour = col[15:0]; cmd_quirk = q; cmd_valid = 1'b1;
        @(posedge clk);
        #1 cmd_valid = 1'b0;
        idx = 0; seen_done = 0;
        for (t = 1; t <= total + 8; t++) begin
            @(negedge clk);
            if (inject && t == 2) begin
                cmd_x = 10'h3C5; cmd_y = 9'h100; cmd_w = 11'h40; cmd_h = 10'h3;
                cmd_colour = 16'h0BAD; cmd_quirk = 1'b1; cmd_valid = 1'b1;
            end
            if (inject && t == 3) cmd_valid = 1'b0;
            if (t == 1 && total > 0)
                check(!cmd_ready && busy, {tag, " R2 not ready while busy"}, cmd_ready, 0);
            if (b0_we || b1_we) begin
                int j, k, row, e0, e1;
                j   = idx / pairs;
                k   = idx % pairs;
                row = (y + j) % 512;
                e1  = row * 512 + (((x >> 4) * 8 + k) % 512);
                e0  = row * 512 + ((b0_base * 8 + k) % 512);
                check(idx < total, {tag, " R4 write count"}, idx, total);
                check(b0_addr == 18'(e0), {tag, " R5 bank0 addr"}, b0_addr, e0);
                check(b1_addr == 18'(e1), {tag, " R5 bank1 addr"}, b1_addr, e1);
                check(b0_we && b1_we && b0_data == col[15:0] && b1_data == col[15:0],
                      {tag, " R9 data/enables"}, b0_data, col);
                idx++;
            end
            if (done) begin
                check(t == total + 1, {tag, " R10 done timing"}, t, total + 1);
                check(busy, {tag, " R10 busy during done"}, busy, 1);
                seen_done = 1;
                break;
            end
        end
        check(seen_done, {tag, " R10 done seen"}, seen_done, 1);
        check(idx == total, {tag, " R4 total writes"}, idx, total);
        @(negedge clk);
        check(cmd_ready && !busy && !done && !b0_we && !b1_we,
              {tag, " R10 idle after done"}, {busy, done, b0_we}, 0);
        if (inject) begin
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                check(!b0_we && !b1_we, {tag, " R12 no writes after ignored cmd"}, b0_we, 0);
            end
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; cmd_valid = 1'b0; cmd_x = '0; cmd_y = '0; cmd_w = '0;
        cmd_h = '0; cmd_colour = '0; cmd_quirk = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(cmd_ready && !busy && !done && !b0_we && !b1_we, "R1 reset state",
              {cmd_ready, busy, done, b0_we}, 8);
    endtask

    task automatic t_normal();   run_fill("R3 x0",       0,     0,     32'h20, 4, 16'h1234, 0, 0); endtask
    task automatic t_normal_f(); run_fill("R3 x0F",      32'h0F, 2,    32'h20, 2, 16'h5555, 0, 0); endtask
    task automatic t_quirk_f();  run_fill("R6 x0F",      32'h0F, 0,    32'h20, 4, 16'h7C1F, 1, 0); endtask
    task automatic t_quirk_1f(); run_fill("R6 x1F",      32'h1F, 5,    32'h20, 3, 16'h03E0, 1, 0); endtask
    task automatic t_quirk_no(); run_fill("R7 x17",      32'h17, 9,    32'h10, 2, 16'hAAAA, 1, 0); endtask
    task automatic t_width();
        run_fill("R4 w1",   32'h40, 1, 1,      2, 16'h0001, 0, 0);
        run_fill("R4 w11h", 32'h25, 1, 32'h11, 1, 16'h0002, 0, 0);
    endtask
    task automatic t_wrap();
        run_fill("R8 wrap quirk",  32'h3FF, 32'h1FE, 32'h30, 4, 16'hFFFF, 1, 0);
        run_fill("R8 wrap normal", 32'h3E3, 32'h1FF, 32'h40, 2, 16'h8001, 0, 0);
    endtask
    task automatic t_zero();
        run_fill("R11 w0", 32'h10, 3, 0,      5, 16'h1111, 0, 0);
        run_fill("R11 h0", 32'h10, 3, 32'h20, 0, 16'h2222, 1, 0);
    endtask
    task automatic t_ignore();   run_fill("R12 busy cmd", 32'h80, 20, 32'h20, 3, 16'h4321, 0, 1); endtask

    initial begin
        t_reset();
        t_normal();
        t_normal_f();
        t_quirk_f();
        t_quirk_1f();
        t_quirk_no();
        t_width();
        t_wrap();
        t_zero();
        t_ignore();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule